// File: doc/BRIEF.md
# Interrupt Context Switch Sequencer

This block is the control and state-holding part of a small 16-bit CPU model that switches context when an interrupt is taken and when a return-from-interrupt instruction completes. The instruction pipeline flags each instruction boundary. At that point the block may accept a pending request whose priority is strictly above the running priority. It then moves the processor onto the supervisor stack and saves the program counter and status word there. It raises the status word to supervisor mode at the device's priority with condition codes cleared, and fetches the handler address from a vector table in memory.

On a return instruction the block pops the status word and then the program counter. When the restored status word is in user mode, it swaps the stack pointers back. The ordinary execution path writes the program counter, status word and stack pointer through a write port, which is ignored while a sequence is running. Memory is a single port with writes on the clock edge and a read latency of one cycle. The stack grows downward: a push decrements SP and then writes, and a pop reads and then increments.

Top module: `ctx_switch_unit`

## Requirements
- R1: After reset the PC is 0x0200, the status word is 0x0000 (user mode, priority 0), SP is 0x0F00, the saved stack pointer is 0x0800, and busy, irqAck, memWe and memRe are all low.
- R2: A request is accepted only in a cycle with instrDone, irqReq and irqPrio strictly greater than status bits 10:8. Otherwise busy stays low and PC and SP are unchanged.
- R3: On entry from user mode (status bit 15 = 0), SP takes the saved supervisor pointer and the saved stack pointer takes the user SP.
- R4: Entry first writes the pre-entry PC at SP-1, then the pre-entry status word at SP-2. Each push decrements SP before its write, so SP ends two below its starting value. A read and a write never occur in the same cycle.
- R5: After entry the status word has bit 15 = 1, bits 10:8 = irqPrio and bits 2:0 (condition codes) = 0, with all other bits unchanged.
- R6: After entry the PC equals the memory word at address 0x0100 + irqVec.
- R7: busy is high for exactly 5 cycles on entry and 3 cycles on return, starting the cycle after acceptance. irqAck is high only in the first entry cycle. Memory is accessed only while busy.
- R8: A return pops the status word from SP, then the PC from SP+1, and leaves SP two higher. If the restored status word has bit 15 = 0, the stack pointers are swapped back.
- R9: A return request while status bit 15 = 0 is ignored: busy stays low and the state is unchanged.
- R10: Entry while already in supervisor mode does no stack swap and pushes onto the current SP.
- R11: Writes from the execution port are ignored while busy.
- R12: When retReq and an acceptable irqReq arrive at the same boundary, the return is performed and the interrupt is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Current instruction has completed (boundary) |
| irqReq | input | 1 | Interrupt request pending |
| irqPrio | input | 3 | Priority level of the requesting device |
| irqVec | input | 8 | Vector table entry number from the device |
| retReq | input | 1 | The completing instruction is a return-from-interrupt |
| execWe | input | 1 | Execution path writes PC, status word and SP |
| execPc | input | 16 | PC value from execution |
| execPsr | input | 16 | Status word value from execution |
| execSp | input | 16 | SP value from execution |
| memRdata | input | 16 | Read data, valid one cycle after memRe |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| busy | output | 1 | A context switch sequence is running |
| irqAck | output | 1 | One-cycle acknowledge of an accepted interrupt |
| pcOut | output | 16 | Program counter |
| psrOut | output | 16 | Processor status word |
| spOut | output | 16 | Active stack pointer |
| savedSpOut | output | 16 | The inactive stack pointer |

## Verification
A wrong stack pointer after the swap shows up within two cycles as a write to the wrong address. A wrong or stale held PC or status word shows up as wrong data in those same writes. A sequencer that skips or repeats a state changes the length of busy and moves the vector read. Any such fault also leaves the PC, status word or stack pointers wrong at the first idle cycle, because every sweep case compares them there. Errors in the return path show up three cycles after the request, and a full entry-then-return round trip makes sure the saved pointer goes back to its starting value.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int WORD_W   = 16;
  localparam int VEC_W    = 8;
  localparam int PRIO_W   = 3;
  localparam int CC_W     = 3;
  localparam int MODE_BIT = 15;
  localparam int PRIO_LO  = 8;
  localparam int CC_LO    = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_SWAP,
    ST_E_PUSH_PC,
    ST_E_PUSH_PSR,
    ST_E_VEC_RD,
    ST_E_VEC_LD,
    ST_R_PSR_RD,
    ST_R_PC_RD,
    ST_R_FINISH
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic enterSwap;
    logic pushPc;
    logic pushPsr;
    logic vecRead;
    logic vecLoad;
    logic popPsrRd;
    logic popPcRd;
    logic popFinish;
  } strobe_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              irqReq,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic              retReq,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic              curSuper,
  output strobe_t           strb,
  output logic              busy,
  output logic              irqAck
);
  seqState_t state, stateNext;
  logic retGo, irqGo;

  // return wins over a simultaneous interrupt at the same boundary
  assign retGo = instrDone & retReq & curSuper;
  assign irqGo = instrDone & irqReq & (irqPrio > curPrio) & ~retGo;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (retGo)      stateNext = ST_R_PSR_RD;
        else if (irqGo) stateNext = ST_E_SWAP;
      end
      ST_E_SWAP:     stateNext = ST_E_PUSH_PC;
      ST_E_PUSH_PC:  stateNext = ST_E_PUSH_PSR;
      ST_E_PUSH_PSR: stateNext = ST_E_VEC_RD;
      ST_E_VEC_RD:   stateNext = ST_E_VEC_LD;
      ST_E_VEC_LD:   stateNext = ST_IDLE;
      ST_R_PSR_RD:   stateNext = ST_R_PC_RD;
      ST_R_PC_RD:    stateNext = ST_R_FINISH;
      ST_R_FINISH:   stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb           = '0;
    strb.capture   = (state == ST_IDLE) & irqGo;
    strb.enterSwap = (state == ST_E_SWAP);
    strb.pushPc    = (state == ST_E_PUSH_PC);
    strb.pushPsr   = (state == ST_E_PUSH_PSR);
    strb.vecRead   = (state == ST_E_VEC_RD);
    strb.vecLoad   = (state == ST_E_VEC_LD);
    strb.popPsrRd  = (state == ST_R_PSR_RD);
    strb.popPcRd   = (state == ST_R_PC_RD);
    strb.popFinish = (state == ST_R_FINISH);
  end

  assign busy   = (state != ST_IDLE);
  assign irqAck = (state == ST_E_SWAP);
endmodule

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'h0100,
  parameter logic [WORD_W-1:0] PC_INIT  = 16'h0200,
  parameter logic [WORD_W-1:0] USP_INIT = 16'h0F00,
  parameter logic [WORD_W-1:0] SSP_INIT = 16'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              idle,
  input  logic              execWe,
  input  logic [WORD_W-1:0] execPc,
  input  logic [WORD_W-1:0] execPsr,
  input  logic [WORD_W-1:0] execSp,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] psrOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] savedSpOut,
  output logic [PRIO_W-1:0] curPrio,
  output logic              curSuper,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe
);
  logic [WORD_W-1:0] pcQ, psrQ, spQ, savedSpQ;
  logic [WORD_W-1:0] holdPc, holdPsr, psrTmp;
  logic [VEC_W-1:0]  vecQ;
  logic [PRIO_W-1:0] prioQ;
  logic [WORD_W-1:0] nextPc, nextPsr, nextSp, enterPsr, spDec, spInc;
  logic              execTake, enterFromUser, leaveToUser;

  assign execTake = execWe & idle;
  assign nextPc   = execTake ? execPc  : pcQ;
  assign nextPsr  = execTake ? execPsr : psrQ;
  assign nextSp   = execTake ? execSp  : spQ;
  assign curPrio  = nextPsr[PRIO_LO +: PRIO_W];
  assign curSuper = nextPsr[MODE_BIT];

  assign spDec = spQ - WORD_W'(1);
  assign spInc = spQ + WORD_W'(1);
  assign enterFromUser = strb.enterSwap & ~psrQ[MODE_BIT];
  assign leaveToUser   = strb.popFinish & ~psrTmp[MODE_BIT];

  always_comb begin
    enterPsr                   = psrQ;
    enterPsr[MODE_BIT]         = 1'b1;
    enterPsr[PRIO_LO +: PRIO_W] = prioQ;
    enterPsr[CC_LO +: CC_W]     = '0;
  end

  // architectural registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= PC_INIT;
      psrQ     <= '0;
      spQ      <= USP_INIT;
      savedSpQ <= SSP_INIT;
    end else begin
      pcQ  <= nextPc;
      psrQ <= nextPsr;
      spQ  <= nextSp;
      if (strb.vecLoad || strb.popFinish) pcQ <= memRdata;
      if (strb.enterSwap) psrQ <= enterPsr;
      if (strb.popFinish) psrQ <= psrTmp;
      if (strb.pushPc || strb.pushPsr)    spQ <= spDec;
      if (strb.popPsrRd || strb.popPcRd)  spQ <= spInc;
      if (enterFromUser || leaveToUser) begin
        spQ      <= savedSpQ;
        savedSpQ <= spQ;
      end
    end
  end

  // sequence holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdPc  <= '0;
      holdPsr <= '0;
      vecQ    <= '0;
      prioQ   <= '0;
      psrTmp  <= '0;
    end else begin
      if (strb.capture) begin
        holdPc  <= nextPc;
        holdPsr <= nextPsr;
        vecQ    <= irqVec;
        prioQ   <= irqPrio;
      end
      if (strb.popPcRd) psrTmp <= memRdata;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWe    = 1'b0;
    memRe    = 1'b0;
    if (strb.pushPc) begin
      memAddr  = spDec;
      memWdata = holdPc;
      memWe    = 1'b1;
    end else if (strb.pushPsr) begin
      memAddr  = spDec;
      memWdata = holdPsr;
      memWe    = 1'b1;
    end else if (strb.vecRead) begin
      memAddr = VEC_BASE + WORD_W'(vecQ);
      memRe   = 1'b1;
    end else if (strb.popPsrRd || strb.popPcRd) begin
      memAddr = spQ;
      memRe   = 1'b1;
    end
  end

  assign pcOut      = pcQ;
  assign psrOut     = psrQ;
  assign spOut      = spQ;
  assign savedSpOut = savedSpQ;
endmodule

// File: rtl/ctx_switch_unit.sv
module ctx_switch_unit
  import ctx_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'h0100,
  parameter logic [WORD_W-1:0] PC_INIT  = 16'h0200,
  parameter logic [WORD_W-1:0] USP_INIT = 16'h0F00,
  parameter logic [WORD_W-1:0] SSP_INIT = 16'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              irqReq,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic              retReq,
  input  logic              execWe,
  input  logic [WORD_W-1:0] execPc,
  input  logic [WORD_W-1:0] execPsr,
  input  logic [WORD_W-1:0] execSp,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic              busy,
  output logic              irqAck,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] psrOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] savedSpOut
);
  strobe_t           strb;
  logic [PRIO_W-1:0] curPrio;
  logic              curSuper;

  ctx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .irqReq(irqReq),
    .irqPrio(irqPrio), .retReq(retReq), .curPrio(curPrio), .curSuper(curSuper),
    .strb(strb), .busy(busy), .irqAck(irqAck)
  );

  ctx_datapath #(
    .VEC_BASE(VEC_BASE), .PC_INIT(PC_INIT), .USP_INIT(USP_INIT), .SSP_INIT(SSP_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idle(~busy), .execWe(execWe),
    .execPc(execPc), .execPsr(execPsr), .execSp(execSp), .irqPrio(irqPrio),
    .irqVec(irqVec), .memRdata(memRdata), .pcOut(pcOut), .psrOut(psrOut),
    .spOut(spOut), .savedSpOut(savedSpOut), .curPrio(curPrio), .curSuper(curSuper),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe)
  );
endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrDone,
  input logic        irqReq,
  input logic        retReq,
  input logic        execWe,
  input logic        busy,
  input logic        irqAck,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] memAddr,
  input logic [15:0] spOut,
  input logic [15:0] psrOut
);
  // R2
  accept_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instrDone));

  // R4
  push_predec_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (spOut == $past(memAddr)));

  // R4
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R5
  enter_psr_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (psrOut[15] && psrOut[2:0] == 3'b000));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  // R7
  mem_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy);

  // R9
  user_ret_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && instrDone && retReq && !irqReq && !execWe && !psrOut[15]) |=> !busy);
endmodule

bind ctx_switch_unit ctx_switch_chk u_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .irqReq(irqReq), .retReq(retReq),
  .execWe(execWe), .busy(busy), .irqAck(irqAck), .memWe(memWe), .memRe(memRe),
  .memAddr(memAddr), .spOut(spOut), .psrOut(psrOut)
);

// File: tb/ctx_switch_unit_bench.sv
module ctx_switch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SSP0  = 16'h0800;
  localparam logic [15:0] USP0  = 16'h0F00;
  localparam logic [15:0] PC0   = 16'h0200;
  localparam logic [15:0] VBASE = 16'h0100;

  logic clk = 1'b0, rstN = 1'b0;
  logic instrDone = 0, irqReq = 0, retReq = 0, execWe = 0;
  logic [2:0] irqPrio = 0;
  logic [7:0] irqVec = 0;
  logic [15:0] execPc = 0, execPsr = 0, execSp = 0, memRdata;
  logic [15:0] memAddr, memWdata, pcOut, psrOut, spOut, savedSpOut;
  logic memWe, memRe, busy, irqAck;
  logic [15:0] mem [0:4095];
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_switch_unit u_ctx_switch_unit (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .irqReq(irqReq), .irqPrio(irqPrio),
    .irqVec(irqVec), .retReq(retReq), .execWe(execWe), .execPc(execPc), .execPsr(execPsr),
    .execSp(execSp), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .busy(busy), .irqAck(irqAck), .pcOut(pcOut),
    .psrOut(psrOut), .spOut(spOut), .savedSpOut(savedSpOut)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[11:0]];
  end

  function automatic logic [15:0] vecVal(input int v);
    return 16'(16'h1000 + v * 3);
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setState(input logic [15:0] p, input logic [15:0] s, input logic [15:0] sp);
    execWe = 1; execPc = p; execPsr = s; execSp = sp;
    @(negedge clk);
    execWe = 0;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic doEntry(input logic [2:0] pr, input logic [7:0] v, input bit expAcc,
                         input bit fromUser);
    logic [15:0] oPc, oPsr, oSp, oSaved, base;
    int n;
    oPc = pcOut; oPsr = psrOut; oSp = spOut; oSaved = savedSpOut;
    instrDone = 1; irqReq = 1; irqPrio = pr; irqVec = v;
    @(negedge clk);
    instrDone = 0; irqReq = 0;
    if (!expAcc) begin
      chk("R2", "busy on rejected request", 16'(busy), 16'd0);
      @(negedge clk);
      chk("R2", "pc kept", pcOut, oPc);
      chk("R2", "sp kept", spOut, oSp);
      return;
    end
    chk("R7", "irqAck first cycle", 16'(irqAck), 16'd1);
    countBusy(n);
    chk("R7", "entry busy cycles", 16'(n), 16'd5);
    base = fromUser ? oSaved : oSp;
    chk(fromUser ? "R3" : "R10", "sp after entry", spOut, 16'(base - 16'd2));
    chk(fromUser ? "R3" : "R10", "saved sp after entry", savedSpOut, fromUser ? oSp : oSaved);
    chk("R4", "pushed pc", mem[12'(base - 16'd1)], oPc);
    chk("R4", "pushed psr", mem[12'(base - 16'd2)], oPsr);
    chk("R5", "psr after entry", psrOut, 16'h8000 | (16'(pr) << 8) | (oPsr & 16'h78F8));
    chk("R6", "pc from vector", pcOut, vecVal(int'(v)));
  endtask

  task automatic doReturn(input bit expAcc, input bit alsoIrq, input logic [15:0] ePc,
                          input logic [15:0] ePsr, input logic [15:0] eSp,
                          input logic [15:0] eSaved);
    int n;
    bit sawAck;
    instrDone = 1; retReq = 1; irqReq = alsoIrq; irqPrio = 3'd7; irqVec = 8'd200;
    @(negedge clk);
    instrDone = 0; retReq = 0; irqReq = 0;
    if (!expAcc) begin
      chk("R9", "busy on user-mode return", 16'(busy), 16'd0);
      @(negedge clk);
    end else begin
      sawAck = irqAck;
      countBusy(n);
      chk(alsoIrq ? "R12" : "R7", "return busy cycles", 16'(n), 16'd3);
      if (alsoIrq) chk("R12", "no ack on return", 16'(sawAck), 16'd0);
    end
    chk(expAcc ? "R8" : "R9", "pc after return", pcOut, ePc);
    chk(expAcc ? "R8" : "R9", "psr after return", psrOut, ePsr);
    chk(expAcc ? "R8" : "R9", "sp after return", spOut, eSp);
    chk(expAcc ? "R8" : "R9", "saved sp after return", savedSpOut, eSaved);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd1, 16'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
    for (int v = 0; v < 256; v++) mem[VBASE + 16'(v)] = vecVal(v);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc reset", pcOut, PC0);
    chk("R1", "psr reset", psrOut, 16'h0000);
    chk("R1", "sp reset", spOut, USP0);
    chk("R1", "saved sp reset", savedSpOut, SSP0);
    chk("R1", "quiet outputs", {12'd0, busy, irqAck, memWe, memRe}, 16'd0);
    rstN = 1;
    @(negedge clk);

    // R2: no acceptance without an instruction boundary
    irqReq = 1; irqPrio = 3'd7;
    @(negedge clk);
    irqReq = 0;
    chk("R2", "no boundary no entry", 16'(busy), 16'd0);

    // R2/R3/R4/R5/R6/R8: priority sweep, round trip each accepted case
    for (int cur = 0; cur < 8; cur++) begin
      for (int rq = 0; rq < 8; rq++) begin
        logic [15:0] p, s;
        p = 16'(PC0 + cur * 8 + rq);
        s = (16'(cur) << 8) | 16'h0025;
        setState(p, s, USP0);
        doEntry(3'(rq), 8'(cur * 8 + rq), rq > cur, 1'b1);
        if (rq > cur) doReturn(1'b1, 1'b0, p, s, USP0, SSP0);
      end
    end

    // R6: every vector entry
    for (int v = 0; v < 256; v++) begin
      logic [15:0] p, s, sp;
      p = 16'(16'h0300 + v); s = 16'(v & 7); sp = 16'(USP0 - 16'(v));
      setState(p, s, sp);
      doEntry(3'd7, 8'(v), 1'b1, 1'b1);
      doReturn(1'b1, 1'b0, p, s, sp, SSP0);
    end

    // R9: return in user mode ignored
    setState(16'h0400, 16'h0102, USP0);
    doReturn(1'b0, 1'b0, 16'h0400, 16'h0102, USP0, SSP0);

    // R10: nested entry, lower priority rejected, R12 on the way out
    doEntry(3'd3, 8'd9, 1'b1, 1'b1);
    doEntry(3'd2, 8'd11, 1'b0, 1'b0);
    doEntry(3'd6, 8'd10, 1'b1, 1'b0);
    doReturn(1'b1, 1'b1, vecVal(9), 16'h8300, 16'(SSP0 - 16'd2), USP0);
    doReturn(1'b1, 1'b0, 16'h0400, 16'h0102, USP0, SSP0);

    // R11: execution writes during a sequence are dropped
    begin
      int n;
      setState(16'h0500, 16'h0000, USP0);
      instrDone = 1; irqReq = 1; irqPrio = 3'd7; irqVec = 8'd77;
      @(negedge clk);
      instrDone = 0; irqReq = 0;
      execWe = 1; execPc = 16'hDEAD; execPsr = 16'h0007; execSp = 16'h0123;
      @(negedge clk);
      @(negedge clk);
      execWe = 0;
      countBusy(n);
      chk("R11", "pc after blocked write", pcOut, vecVal(77));
      chk("R11", "psr after blocked write", psrOut, 16'h8700);
      chk("R11", "sp after blocked write", spOut, 16'(SSP0 - 16'd2));
      chk("R11", "pushed pc kept", mem[12'(SSP0 - 16'd1)], 16'h0500);
      doReturn(1'b1, 1'b0, 16'h0500, 16'h0000, USP0, SSP0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule